// File: doc/BRIEF.md
# Vertical Sync Separator with Noise Shaping

This block finds the vertical sync interval in a digitized composite-sync stream that is sampled on the pixel master clock, and marks it with a one-clock vertical-reset strobe. Downstream timing generators use this strobe to realign their line and field counters. The input is high while the sync tip is present. Horizontal sync pulses, equalizing pulses and the narrow serrations inside the vertical interval must not produce the strobe on their own.

The first rising sample seen while the block is idle opens a measurement window of fixed length. Within that window, the width of each qualifying sync pulse is added to a saturating accumulator when the pulse ends. Runs that are too short to be sync are dropped as noise. A qualifying pulse starts a short recovery period. A pulse that begins inside that period is credited with twice its width, so broad vertical pulses that are broken up by unusually narrow serrations still add up quickly. When the accumulator reaches the threshold before the decision deadline of the window, one strobe is issued. The block then holds off until the window closes. Every duration is a parameter in clock counts. The defaults assume 10 clocks per microsecond: a 190 µs window, a 125 µs deadline, a 15 µs recovery period and a 1 µs noise floor.

Top module: `vsync_separator`

## Requirements
- R1: A synchronous active-high reset holds `vReset` low, closes any window and clears the accumulator and the recovery timer. After reset is released, no strobe appears until fresh pulses reach the threshold.
- R2: A high run of fewer than MIN_W samples is noise. It adds nothing to the accumulator and starts no recovery period.
- R3: A pulse of w high samples (w ≥ MIN_W) adds w to the accumulator on its first low sample, provided a window is open at that sample.
- R4: A qualifying pulse adds 2·w instead when its first high sample follows the first low sample of the previous qualifying pulse by at most REC_LEN samples.
- R5: `vReset` is high for exactly one clock. It rises on the clock after the sample at which the accumulator first reaches ACC_THR.
- R6: A window opens on a rising sample that arrives while no window is open. The accumulator is cleared at that point, and the window covers WIN_LEN samples counted from the opening sample.
- R7: At most one strobe is issued per window. Further pulses in the same window cause none.
- R8: A strobe is issued only when the pulse that reaches the threshold ends less than DEC_LEN samples after the window opened. Reaching the threshold later gives no strobe.
- R9: The accumulator saturates at its all-ones value instead of wrapping. A doubled pulse that would overflow it still reaches the threshold.
- R10: A rising sample inside an open window never opens a new window. A pulse whose first low sample arrives after the window has closed adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel master clock |
| rst | input | 1 | Synchronous reset, active high |
| syncIn | input | 1 | Composite sync sample, high during sync tip |
| vReset | output | 1 | One-clock vertical-reset strobe |

## Verification
A pulse's width is credited on the edge that samples its first low value. The strobe follows one clock after that edge, so it is visible one full cycle after the falling sample is taken. The bench keeps a behavioural model that advances on the same rising edge as the design. It compares `vReset` with the model at every falling clock edge, half a cycle after any change. Each scenario then counts the strobes it produced and checks that count against a value worked out by hand from the pulse widths and gaps. The scenarios include ones built to sit just above or just below the threshold, the recovery limit and the decision deadline.

// File: rtl/vsep_pkg.sv
package vsep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_HOLD
  } vsepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;
    logic commit;
    logic active;
  } vsepCtrl_t;

  // raw conditions from datapath to control
  typedef struct packed {
    logic rise;
    logic fall;
    logic widthOk;
    logic accHit;
    logic decOpen;
    logic winLast;
  } vsepStat_t;

endpackage

// File: rtl/vsep_datapath.sv
module vsep_datapath
  import vsep_pkg::*;
#(
  parameter int WIN_LEN = 1900,
  parameter int DEC_LEN = 1250,
  parameter int REC_LEN = 150,
  parameter int MIN_W   = 10,
  parameter int ACC_THR = 600,
  parameter int ACC_W   = 12,
  parameter int WID_W   = 12
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      syncIn,
  input  vsepCtrl_t ctrl,
  output vsepStat_t stat
);

  localparam int WC_W  = $clog2(WIN_LEN);
  localparam int RC_W  = $clog2(REC_LEN + 1);
  localparam int SUM_W = ((ACC_W > WID_W + 1) ? ACC_W : WID_W + 1) + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [WID_W-1:0] WID_MAX = '1;

  logic             syncPrev;
  logic [WID_W-1:0] widthCnt;
  logic             pulseDbl;
  logic [RC_W-1:0]  recCnt;
  logic [WC_W-1:0]  winCnt;
  logic [ACC_W-1:0] acc;

  logic [SUM_W-1:0] addend;
  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] accNext;

  always_comb begin
    stat.rise    = syncIn & ~syncPrev;
    stat.fall    = ~syncIn & syncPrev;
    stat.widthOk = 32'(widthCnt) >= MIN_W;
    stat.accHit  = 32'(acc) >= ACC_THR;
    stat.decOpen = 32'(winCnt) < DEC_LEN;
    stat.winLast = 32'(winCnt) == WIN_LEN - 1;
  end

  // doubled credit for pulses that began inside the recovery period
  always_comb begin
    addend  = pulseDbl ? SUM_W'({widthCnt, 1'b0}) : SUM_W'(widthCnt);
    sum     = SUM_W'(acc) + addend;
    accNext = (sum > SUM_W'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncPrev <= 1'b0;
      widthCnt <= '0;
      pulseDbl <= 1'b0;
      recCnt   <= '0;
      winCnt   <= '0;
      acc      <= '0;
    end else begin
      syncPrev <= syncIn;

      if (stat.rise) begin
        widthCnt <= WID_W'(1);
        pulseDbl <= (recCnt != '0);
      end else if (syncIn && widthCnt != WID_MAX) begin
        widthCnt <= widthCnt + 1'b1;
      end

      if (stat.fall && stat.widthOk) recCnt <= RC_W'(REC_LEN);
      else if (recCnt != '0)         recCnt <= recCnt - 1'b1;

      if (ctrl.openWin)                      winCnt <= '0;
      else if (ctrl.active && !stat.winLast) winCnt <= winCnt + 1'b1;

      if (ctrl.openWin)     acc <= '0;
      else if (ctrl.commit) acc <= accNext;
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ctrl.commit |=> acc >= $past(acc)); // R9

  AST_NOISE_NO_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    (stat.fall && !stat.widthOk && recCnt == '0) |=> recCnt == '0); // R2

  AST_CLEAR_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
    ctrl.openWin |=> acc == '0); // R6

endmodule

// File: rtl/vsep_control.sv
module vsep_control
  import vsep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  vsepStat_t stat,
  output vsepCtrl_t ctrl,
  output logic      fire
);

  vsepState_t state;
  logic       active;
  logic       winEnd;
  logic       fireNow;
  logic       fireQ;

  always_comb begin
    active       = (state != ST_IDLE);
    winEnd       = active & stat.winLast;
    ctrl.active  = active;
    ctrl.openWin = ~active & stat.rise;
    ctrl.commit  = stat.fall & stat.widthOk & active & ~winEnd;
    fireNow      = (state == ST_OPEN) & stat.accHit & stat.decOpen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      fireQ <= 1'b0;
    end else begin
      fireQ <= fireNow;
      if (ctrl.openWin)  state <= ST_OPEN;
      else if (winEnd)   state <= ST_IDLE;
      else if (fireNow)  state <= ST_HOLD;
    end
  end

  assign fire = fireQ;

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fireQ |=> !fireQ); // R5

  AST_HOLD_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |=> !fireQ); // R7

  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (winEnd && !stat.rise) |=> state == ST_IDLE); // R10

endmodule

// File: rtl/vsync_separator.sv
module vsync_separator
  import vsep_pkg::*;
#(
  parameter int CLK_PER_US = 10,
  parameter int WIN_LEN    = 190 * CLK_PER_US,
  parameter int DEC_LEN    = 125 * CLK_PER_US,
  parameter int REC_LEN    = 15 * CLK_PER_US,
  parameter int MIN_W      = CLK_PER_US,
  parameter int ACC_THR    = 60 * CLK_PER_US,
  parameter int ACC_W      = 12,
  parameter int WID_W      = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic syncIn,
  output logic vReset
);

  vsepCtrl_t ctrl;
  vsepStat_t stat;

  vsep_datapath #(
    .WIN_LEN(WIN_LEN), .DEC_LEN(DEC_LEN), .REC_LEN(REC_LEN),
    .MIN_W(MIN_W), .ACC_THR(ACC_THR), .ACC_W(ACC_W), .WID_W(WID_W)
  ) uDp (
    .clk(clk), .rst(rst), .syncIn(syncIn), .ctrl(ctrl), .stat(stat)
  );

  vsep_control uCtl (
    .clk(clk), .rst(rst), .stat(stat), .ctrl(ctrl), .fire(vReset)
  );

  AST_DECISION_OPEN: assert property (@(posedge clk) disable iff (rst)
    vReset |-> $past(stat.decOpen)); // R8

  AST_NO_FIRE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> !vReset); // R1

endmodule

// File: tb/sim_vsync_separator.sv
`timescale 1ns/1ps
module sim_vsync_separator;

  localparam int WIN_LEN = 400;
  localparam int DEC_LEN = 260;
  localparam int REC_LEN = 30;
  localparam int MIN_W   = 4;
  localparam int ACC_THR = 120;
  localparam int ACC_W   = 8;
  localparam int WID_W   = 8;
  localparam int ACC_MAXI = (1 << ACC_W) - 1;
  localparam int WID_MAXI = (1 << WID_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic syncIn = 1'b0;
  logic vReset;

  vsync_separator #(
    .WIN_LEN(WIN_LEN), .DEC_LEN(DEC_LEN), .REC_LEN(REC_LEN),
    .MIN_W(MIN_W), .ACC_THR(ACC_THR), .ACC_W(ACC_W), .WID_W(WID_W)
  ) u0 (
    .clk(clk), .rst(rst), .syncIn(syncIn), .vReset(vReset)
  );

  always #2.5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  int    fireSeen = 0;
  int    cycle = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference model
  int mPrev, mW, mDbl, mRec, mState, mWc, mAcc, mFire;
  int rise, fall, active, winEnd, hit, open, commit, nFire, credit;

  always @(posedge clk) begin
    cycle++;
    if (rst) begin
      mPrev = 0; mW = 0; mDbl = 0; mRec = 0;
      mState = 0; mWc = 0; mAcc = 0; mFire = 0;
    end else begin
      rise   = (syncIn && !mPrev) ? 1 : 0;
      fall   = (!syncIn && mPrev) ? 1 : 0;
      active = (mState != 0) ? 1 : 0;
      winEnd = (active && mWc == WIN_LEN - 1) ? 1 : 0;
      hit    = (mAcc >= ACC_THR) ? 1 : 0;
      open   = (!active && rise) ? 1 : 0;
      commit = (fall && mW >= MIN_W && active && !winEnd) ? 1 : 0;
      nFire  = (mState == 1 && hit && mWc < DEC_LEN) ? 1 : 0;
      credit = mDbl ? 2 * mW : mW;

      if (open)        mAcc = 0;
      else if (commit) mAcc = (mAcc + credit > ACC_MAXI) ? ACC_MAXI : mAcc + credit;

      if (open)        mState = 1;
      else if (winEnd) mState = 0;
      else if (nFire)  mState = 2;

      if (open)        mWc = 0;
      else if (active) mWc = mWc + 1;

      if (fall && mW >= MIN_W) mRec = REC_LEN;
      else if (mRec > 0)       mRec = mRec - 1;

      if (rise) begin
        mDbl = (mRec_before() != 0) ? 1 : 0;
        mW = 1;
      end else if (syncIn && mW < WID_MAXI) begin
        mW = mW + 1;
      end

      mPrev = syncIn ? 1 : 0;
      mFire = nFire;
    end
  end

  // recovery state as it stood before this edge
  int recSaved;
  always @(negedge clk) recSaved = mRec;
  function automatic int mRec_before();
    return recSaved;
  endfunction

  // compare against the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (vReset !== mFire[0]) begin
        errors++;
        $display("FAIL %s: vReset act=%0b exp=%0b at cycle %0d", tag, vReset, mFire[0], cycle);
      end
      if (vReset) fireSeen++;
    end
  end

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", t, act, exp);
    end
  endtask

  task automatic drive(input int hi, input int lo);
    syncIn = 1'b1;
    repeat (hi) @(negedge clk);
    syncIn = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic begin_scen(input string t);
    tag = t;
    fireSeen = 0;
  endtask

  task automatic end_scen(input int exp);
    repeat (450) @(negedge clk);
    check({tag, " strobe count"}, fireSeen, exp);
  endtask

  initial begin
    // R1: reset state
    repeat (5) begin
      @(negedge clk);
      check("R1 during reset", int'(vReset), 0);
    end
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 idle after reset", int'(vReset), 0);

    // R3: two single-weight pulses reach the threshold
    begin_scen("R3");
    drive(70, 50); drive(70, 0);
    end_scen(1);

    // R3: short line-rate pulses stay below the threshold
    begin_scen("R3_line");
    repeat (4) drive(20, 100);
    end_scen(0);

    // R4: doubled credit inside recovery
    begin_scen("R4");
    drive(40, 20); drive(40, 0);
    end_scen(1);

    // R2: noise run neither counts nor restarts recovery
    begin_scen("R2");
    drive(40, 20); drive(3, 20); drive(40, 0);
    end_scen(0);

    begin_scen("R2_glitch");
    repeat (10) drive(3, 5);
    end_scen(0);

    // R7: one strobe per window
    begin_scen("R7");
    drive(70, 50); drive(70, 20); drive(70, 20); drive(70, 0);
    end_scen(1);

    // R8: threshold reached after the deadline
    begin_scen("R8");
    repeat (4) drive(30, 60);
    end_scen(0);

    // R9: saturation instead of wrap
    begin_scen("R9");
    drive(100, 10); drive(100, 0);
    end_scen(1);

    // R6: accumulator cleared on a new window
    begin_scen("R6");
    drive(100, 450); drive(60, 0);
    end_scen(0);

    // R10: pulse straddling window end adds nothing
    begin_scen("R10");
    drive(10, 290); drive(130, 50); drive(110, 0);
    end_scen(0);

    // R1: reset in the middle of a window clears the partial sum
    begin_scen("R1_mid");
    drive(70, 20);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    drive(70, 0);
    end_scen(0);

    // R5: a strobe lasts one clock (model comparison checks width)
    begin_scen("R5");
    drive(130, 0);
    end_scen(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL %s watchdog: act=running exp=finished", tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule